// File: doc/BRIEF.md
# Pulse-Gap Forward Link Modulator

This block keys the field-enable line of a low-frequency reader so that a bit stream reaches a transponder by gap timing. A zero is marked by a short field-off gap followed by an on-dwell. A one is marked by an on-dwell with no gap. Every frame opens with a long start gap and then an on-dwell. The first stored entry of the frame is spent on this start condition and is never encoded as data.

A host builds the frame itself, such as a command, an address, data or a password. It places one entry per bit on `entries`, sets `bit_count` and pulses `start`. The block latches the frame and times every interval by counting pulses of the 1 µs `tick_us` input. It can optionally keep the field on for a long hold after the last bit, which gives the tag time to process a write or a login. At the end it drops the field and pulses `done`.

Top module: `pgm_fwd_link`

## Requirements
- R1: After reset, and whenever no frame is in progress, `field_en`, `busy` and `done` are all low.
- R2: A `start` pulse taken while idle raises `busy` and begins a frame with the field off for START_GAP_US ticks (default 448), then on for START_ON_US ticks (default 128).
- R3: Each data bit whose value is 1 keeps the field on for ONE_ON_US ticks (default 256), with no gap.
- R4: Each data bit whose value is 0 turns the field off for ZERO_GAP_US ticks (default 128), then on for ZERO_ON_US ticks (default 128).
- R5: Entry 0 is used up by the start condition. A count of N (1 to 64) encodes entries 1 to N-1 in ascending order, so a count of 1 sends only the start condition.
- R6: Entry k occupies `entries[k*ENTRY_W +: ENTRY_W]` (ENTRY_W defaults to 8), and only its bit 0 decides the bit value. The upper bits of an entry have no effect.
- R7: When `hold_en` is high at the accepted `start`, the field stays on for a further HOLD_US ticks (default 20000) after the final dwell and before it turns off.
- R8: A frame ends with `done` high for exactly one cycle. In that same cycle `field_en` and `busy` go low.
- R9: A `start` pulse that arrives while `busy` is high is ignored. The frame in progress continues unchanged, and no further frame follows it.
- R10: Every interval lasts an exact number of `tick_us` pulses. The first interval is counted from the tick after the accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle pulse every microsecond |
| start | input | 1 | Begin a frame when idle |
| entries | input | MAX_BITS*ENTRY_W | Bit entries of the frame; bit 0 of each entry is the bit value |
| bit_count | input | $clog2(MAX_BITS+1) | Number of entries in the frame, 1 to MAX_BITS |
| hold_en | input | 1 | Add the post-frame hold with the field on |
| field_en | output | 1 | Reader field enable, 1 = field on |
| busy | output | 1 | A frame is in progress |
| done | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The bench converts each frame into the expected run of on and off intervals, with adjacent intervals of the same level merged. It then measures the interval lengths on `field_en` while ticks arrive every second cycle. The test frames are:
- a single-entry frame, which shows that only the start condition is sent;
- a mixed pattern whose entries carry junk in their upper bits, which separates bit 0 from the rest of the entry;
- a full 64-entry frame with the hold enabled, which covers the longest frame, the bit order and the merged final dwell;
- an all-zero frame during which `start` is pulsed again with other data, which shows that the latched frame is kept and that no second frame starts.

// File: rtl/pgm_pkg.sv
package pgm_pkg;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_START_OFF,
        PH_START_ON,
        PH_ONE_ON,
        PH_ZERO_OFF,
        PH_ZERO_ON,
        PH_HOLD
    } phase_e;

    // Field level that belongs to each phase
    function automatic logic phase_field(input phase_e ph);
        case (ph)
            PH_START_ON, PH_ONE_ON, PH_ZERO_ON, PH_HOLD: return 1'b1;
            default:                                     return 1'b0;
        endcase
    endfunction

    function automatic int max_int(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/pgm_tick_timer.sv
module pgm_tick_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             tick,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expire
);
    logic [CNT_W-1:0] cnt;

    assign expire = run && tick && (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= load_val - 1'b1;
        end else if (run && tick && cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    // R10
    tick_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !tick) |=> $stable(cnt));

endmodule

// File: rtl/pgm_bit_feed.sv
module pgm_bit_feed #(
    parameter int MAX_BITS = 64,
    parameter int ENTRY_W  = 8,
    localparam int CW      = $clog2(MAX_BITS + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        load,
    input  logic [MAX_BITS*ENTRY_W-1:0] entries_in,
    input  logic [CW-1:0]               count_in,
    input  logic                        consume,
    output logic                        more,
    output logic                        cur_bit
);
    logic [MAX_BITS-1:0] lsb_in;
    logic [MAX_BITS-1:0] lsb_q;
    logic [CW-1:0]       rem;

    // Keep only the deciding bit of each entry
    for (genvar k = 0; k < MAX_BITS; k++) begin : g_lsb
        assign lsb_in[k] = entries_in[k*ENTRY_W];
    end

    assign more    = (rem != '0);
    assign cur_bit = lsb_q[1];

    always_ff @(posedge clk) begin
        if (rst) begin
            lsb_q <= '0;
            rem   <= '0;
        end else if (load) begin
            lsb_q <= lsb_in;
            rem   <= (count_in == '0) ? '0 : count_in - 1'b1;
        end else if (consume) begin
            lsb_q <= lsb_q >> 1;
            rem   <= rem - 1'b1;
        end
    end

    // R5
    rem_underflow_chk: assert property (@(posedge clk) disable iff (rst)
        consume |-> (rem != '0));

    // R9
    feed_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!load && !consume) |=> ($stable(rem) && $stable(lsb_q)));

endmodule

// File: rtl/pgm_fwd_link.sv
module pgm_fwd_link
    import pgm_pkg::*;
#(
    parameter int MAX_BITS    = 64,
    parameter int ENTRY_W     = 8,
    parameter int START_GAP_US = 448,
    parameter int START_ON_US  = 128,
    parameter int ONE_ON_US    = 256,
    parameter int ZERO_GAP_US  = 128,
    parameter int ZERO_ON_US   = 128,
    parameter int HOLD_US      = 20000,
    localparam int CW    = $clog2(MAX_BITS + 1),
    localparam int MAXD  = max_int(max_int(max_int(START_GAP_US, START_ON_US),
                                           max_int(ONE_ON_US, ZERO_GAP_US)),
                                   max_int(ZERO_ON_US, HOLD_US)),
    localparam int CNT_W = $clog2(MAXD + 1)
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tick_us,
    input  logic                        start,
    input  logic [MAX_BITS*ENTRY_W-1:0] entries,
    input  logic [CW-1:0]               bit_count,
    input  logic                        hold_en,
    output logic                        field_en,
    output logic                        busy,
    output logic                        done
);
    phase_e           phase, nxt;
    logic             load, consume, fin, expire, more, cur_bit;
    logic             hold_q, field_q, done_q;
    logic [CNT_W-1:0] dur;

    pgm_tick_timer #(.CNT_W(CNT_W)) u_timer (
        .clk(clk), .rst(rst), .run(phase != PH_IDLE), .tick(tick_us),
        .load(load), .load_val(dur), .expire(expire)
    );

    pgm_bit_feed #(.MAX_BITS(MAX_BITS), .ENTRY_W(ENTRY_W)) u_feed (
        .clk(clk), .rst(rst), .load(phase == PH_IDLE && start),
        .entries_in(entries), .count_in(bit_count), .consume(consume),
        .more(more), .cur_bit(cur_bit)
    );

    always_comb begin
        nxt     = phase;
        load    = 1'b0;
        consume = 1'b0;
        fin     = 1'b0;
        dur     = '0;
        case (phase)
            PH_IDLE: if (start) begin
                nxt = PH_START_OFF; load = 1'b1; dur = CNT_W'(START_GAP_US);
            end
            PH_START_OFF: if (expire) begin
                nxt = PH_START_ON; load = 1'b1; dur = CNT_W'(START_ON_US);
            end
            PH_ZERO_OFF: if (expire) begin
                nxt = PH_ZERO_ON; load = 1'b1; dur = CNT_W'(ZERO_ON_US);
            end
            PH_START_ON, PH_ONE_ON, PH_ZERO_ON: if (expire) begin
                if (more) begin
                    consume = 1'b1;
                    load    = 1'b1;
                    if (cur_bit) begin
                        nxt = PH_ONE_ON;   dur = CNT_W'(ONE_ON_US);
                    end else begin
                        nxt = PH_ZERO_OFF; dur = CNT_W'(ZERO_GAP_US);
                    end
                end else if (hold_q) begin
                    nxt = PH_HOLD; load = 1'b1; dur = CNT_W'(HOLD_US);
                end else begin
                    nxt = PH_IDLE; fin = 1'b1;
                end
            end
            PH_HOLD: if (expire) begin
                nxt = PH_IDLE; fin = 1'b1;
            end
            default: nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase   <= PH_IDLE;
            field_q <= 1'b0;
            done_q  <= 1'b0;
            hold_q  <= 1'b0;
        end else begin
            phase   <= nxt;
            field_q <= phase_field(nxt);
            done_q  <= fin;
            if (phase == PH_IDLE && start) hold_q <= hold_en;
        end
    end

    assign field_en = field_q;
    assign busy     = (phase != PH_IDLE);
    assign done     = done_q;

    // R1
    idle_field_low_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !field_en);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    done_end_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !field_en && $past(busy)));

    // R9
    hold_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && start) |=> $stable(hold_q));

endmodule

// File: tb/pgm_fwd_link_test.sv
module pgm_fwd_link_test;
    localparam int MAXB  = 64;
    localparam int EW    = 8;
    localparam int CW    = $clog2(MAXB + 1);
    localparam int TDIV  = 2;
    localparam int T_SG  = 448;
    localparam int T_SO  = 128;
    localparam int T_ONE = 256;
    localparam int T_ZG  = 128;
    localparam int T_ZO  = 128;
    localparam int T_HLD = 300;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tick_us = 1'b0;
    logic start = 1'b0;
    logic [MAXB*EW-1:0] entries = '0;
    logic [CW-1:0] bit_count = '0;
    logic hold_en = 1'b0;
    logic field_en, busy, done;

    int n_tests = 0;
    int n_fail = 0;
    int cyc = 0;
    int frames_done = 0;
    int exp_lvl[$];
    int exp_dur[$];
    bit finished = 0;

    always #10 clk = ~clk;

    pgm_fwd_link #(.MAX_BITS(MAXB), .ENTRY_W(EW), .HOLD_US(T_HLD)) uut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .start(start),
        .entries(entries), .bit_count(bit_count), .hold_en(hold_en),
        .field_en(field_en), .busy(busy), .done(done)
    );

    task automatic chk(input bit ok, input string req, input int act, input int expv);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, expv);
        end
    endtask

    // Tick generator, driven away from the active edge
    initial begin
        forever begin
            @(negedge clk);
            tick_us = ((cyc % TDIV) == 0);
        end
    end

    // Expected-interval builder: merges neighbours of equal level
    task automatic push_seg(input int lvl, input int d);
        if (exp_lvl.size() > 0 && exp_lvl[$] == lvl) exp_dur[$] = exp_dur[$] + d;
        else begin exp_lvl.push_back(lvl); exp_dur.push_back(d); end
    endtask

    function automatic logic [MAXB*EW-1:0] make_entries(input logic [MAXB-1:0] b);
        logic [MAXB*EW-1:0] e;
        for (int k = 0; k < MAXB; k++) e[k*EW +: EW] = {7'(8'h5A ^ 8'(k * 3)), b[k]};
        return e;
    endfunction

    // Driver: pushes expected intervals, then starts the frame
    task automatic send(input logic [MAXB-1:0] b, input int cnt, input bit hold);
        int target;
        push_seg(0, T_SG);                 // R2 start gap
        push_seg(1, T_SO);
        for (int k = 1; k < cnt; k++) begin // R5 entries 1..cnt-1
            if (b[k]) push_seg(1, T_ONE);   // R3
            else begin push_seg(0, T_ZG); push_seg(1, T_ZO); end // R4
        end
        if (hold) push_seg(1, T_HLD);       // R7
        target = frames_done + 1;
        @(negedge clk);
        entries = make_entries(b);
        bit_count = CW'(cnt);
        hold_en = hold;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait (frames_done == target);
    endtask

    // Monitor / scoreboard
    logic busy_p = 1'b0, field_p = 1'b0, done_p = 1'b0;
    int last = 0;
    bit first = 0;
    initial begin
        forever begin
            @(negedge clk);
            cyc++;
            if (!rst) begin
                if (busy && !busy_p) begin first = 1; last = cyc; end
                if (field_en !== field_p && (busy || done)) begin
                    int len, el, ed;
                    len = cyc - last;
                    if (exp_lvl.size() == 0) begin
                        chk(0, "R2 unexpected interval", len, 0);
                    end else begin
                        el = exp_lvl.pop_front();
                        ed = exp_dur.pop_front();
                        chk(int'(field_p) == el, "R3/R4 interval level", int'(field_p), el);
                        if (first)
                            chk(len > (ed - 1) * TDIV && len <= ed * TDIV,
                                "R2 R10 start gap length", len, ed * TDIV);
                        else
                            chk(len == ed * TDIV, "R3 R4 R10 interval length", len, ed * TDIV);
                    end
                    first = 0;
                    last = cyc;
                end
                if (done) begin
                    chk(!busy && !field_en, "R8 outputs at done", {busy, field_en}, 0);
                    chk(exp_lvl.size() == 0, "R5 R7 all intervals seen", exp_lvl.size(), 0);
                    chk(!done_p, "R8 done single cycle", 1, 0);
                    frames_done++;
                end
                if (done_p)
                    chk(!done, "R8 done drops", int'(done), 0);
            end
            busy_p = busy;
            field_p = field_en;
            done_p = done;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(field_en == 1'b0, "R1 field after reset", int'(field_en), 0);
        chk(busy == 1'b0, "R1 busy after reset", int'(busy), 0);
        chk(done == 1'b0, "R1 done after reset", int'(done), 0);

        // R5 count 1 sends only the start condition
        send(64'hFFFF_FFFF_FFFF_FFFF, 1, 0);
        // R6 mixed bits with junk upper entry bits
        send(64'h0000_0000_0000_004D, 8, 0);
        // R7 full frame with hold
        send(64'hA5F0_3C96_0F1E_7B2D, 64, 1);

        // R9 all-zero frame with a start pulse mid-frame
        fork
            send(64'h0, 6, 1);
            begin
                repeat (1500) @(negedge clk);
                entries = make_entries(64'hFFFF_FFFF_FFFF_FFFF);
                bit_count = CW'(1);
                hold_en = 1'b0;
                start = 1'b1;
                @(negedge clk);
                start = 1'b0;
            end
        join
        repeat (20) @(negedge clk);
        chk(busy == 1'b0, "R9 no frame after ignored start", int'(busy), 0);
        chk(field_en == 1'b0, "R1 field idle between frames", int'(field_en), 0);

        // R3 short run of ones
        send(64'h0000_0000_0000_000E, 4, 0);
        repeat (5) @(negedge clk);
        chk(busy == 1'b0 && field_en == 1'b0, "R1 idle after frame", {busy, field_en}, 0);

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule